// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block is the digital control side of a serial successive-approximation converter. It runs on the serial clock and watches the serial data input for a start bit. It then shifts in the rest of an 8-bit control byte. From that byte it takes the input range and a two-bit mode field, and it times acquisition, the conversion gap and the 16-bit result window, all counted in serial clocks. A register input stands in for the analog value.

The mode field chooses among four behaviours. Two set the acquisition length (short or long). One starts a calibration run that can be aborted. One asks for a software sleep after the current conversion. An active-low reset and an active-low shutdown input can stop any activity.

Top module: `adcConvSeq`

## Requirements
- R1: While `rstN` is low, `acqActive`, `rangeBip`, `calBusy` and `sdo` are low. The stored range returns to unipolar and the stored acquisition length returns to short.
- R2: When `sdi` is sampled high by a rising edge outside a conversion, with `shdnN` high, that bit is taken as a start bit. `acqActive` is high from the next cycle. `rangeBip` keeps the previous conversion's range until the range bit has been taken in.
- R3: The control byte's bits follow the start bit on successive rising edges in this order: range, M1, M0, then four pad bits. A range bit of 1 selects bipolar. `rangeBip` shows the new range from the cycle after that bit, which is during acquisition, and holds it until the next range bit.
- R4: Mode M1:M0 = 00 sets the short length. Counting the cycle after the start bit as cycle 1, `acqActive` is high in cycles 1 to 6, the input is captured on the falling edge of cycle 6, and the conversion ends after cycle 24.
- R5: Mode 11 sets the long length. Acquisition covers cycles 1 to 14 and the conversion ends after cycle 32.
- R6: Mode 10 uses the acquisition length stored by the last conversion that had mode 00 or 11. After that conversion ends, `sleepFlag` stays high until the next start bit.
- R7: Mode 01 starts calibration once the byte is complete. `acqActive` falls once M0 is known. `calBusy` is then high for exactly CAL_CYCLES cycles, after which the block is idle.
- R8: A start bit ends calibration and begins acquisition. Calibration is also ended by `shdnN` low and by `rstN` low.
- R9: The result is sent MSB first on `sdo`, which changes on falling edges, during the last 16 cycles of the conversion. `sdo` is low at all other times. A unipolar result equals `anaLevel`. A bipolar result is `anaLevel` with bit 15 inverted, which gives two's complement.
- R10: Within a conversion, `sdi` is ignored after the range and mode bits. Pad bits and high levels during the output window neither restart nor change the conversion.
- R11: While `shdnN` is low, any conversion or calibration stops, `sleepFlag` is high and start bits are ignored. The stored range and acquisition length are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shdnN | input | 1 | Shutdown, active low |
| sdi | input | 1 | Serial control data in |
| anaLevel | input | 16 | Stand-in for the sampled analog level, offset binary |
| sdo | output | 1 | Serial result out, MSB first |
| acqActive | output | 1 | Input acquisition window |
| rangeBip | output | 1 | Current range: 1 bipolar, 0 unipolar |
| calBusy | output | 1 | Calibration in progress |
| sleepFlag | output | 1 | Software sleep or shutdown pin active |

## Verification
The bench runs conversions with each of the four mode codes. Short and long modes show whether the acquisition end and period length follow the code. A sleep-code conversion that follows a long conversion shows whether the stored length is reused and not reset to short. Range flips in both directions show whether the old range holds until the range bit arrives. Levels of 0x0001, 0xFFFF and 0x8000 separate plain binary from two's complement coding, since the MSB is inverted for bipolar. Pad bits of all ones, and `sdi` held high through the output window, expose any late restart. Calibration is run to completion once and is also cut short by a start bit, by the shutdown pin and by reset. The shutdown pin is also pulled low in the middle of a result while `sdi` pulses, to check that starts are ignored.

// File: rtl/adcConvSeqPkg.sv
package adcConvSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_CAL   = 2'd2,
    ST_SLEEP = 2'd3
  } seqState_e;

  // mode field as received, M1 first
  typedef enum logic [1:0] {
    MD_SHORT = 2'b00,
    MD_CAL   = 2'b01,
    MD_SLEEP = 2'b10,
    MD_LONG  = 2'b11
  } modeCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take the analog level this falling edge
    logic shiftOn;   // present next result bit this falling edge
    logic bipolar;   // coding for capture
  } dpStrobe_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcConvSeqPkg::*;
#(
  parameter int RES_W         = 16,
  parameter int CTRL_W        = 8,
  parameter int SHORT_ACQ_END = 6,
  parameter int LONG_EXTRA    = 8,
  parameter int CAL_CYCLES    = 80000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      shdnN,
  input  logic      sdi,
  output dpStrobe_t strobe,
  output logic      acqActive,
  output logic      rangeBip,
  output logic      calBusy,
  output logic      sleepFlag
);

  localparam int SHORT_PERIOD = CTRL_W + RES_W;
  localparam int LONG_PERIOD  = SHORT_PERIOD + LONG_EXTRA;
  localparam int CNT_W        = $clog2(LONG_PERIOD + 1);
  localparam int CAL_W        = $clog2(CAL_CYCLES + 1);
  localparam int RANGE_POS    = 1;
  localparam int M1_POS       = 2;
  localparam int M0_POS       = 3;
  localparam int LAST_CTRL    = CTRL_W - 1;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CAL_W-1:0] calCnt;
  logic             longSel;
  logic             m1Reg;
  logic             calReq;
  logic             sleepReq;
  logic             rangeReg;

  logic [CNT_W-1:0] acqEnd;
  logic [CNT_W-1:0] periodEnd;
  logic [CNT_W-1:0] outFirst;
  logic             startOk;
  logic             convPhase;
  modeCode_e        modeNow;

  always_comb begin
    acqEnd    = longSel ? CNT_W'(SHORT_ACQ_END + LONG_EXTRA) : CNT_W'(SHORT_ACQ_END);
    periodEnd = longSel ? CNT_W'(LONG_PERIOD) : CNT_W'(SHORT_PERIOD);
    outFirst  = periodEnd - CNT_W'(RES_W - 1);
    startOk   = shdnN && sdi && (state != ST_CONV);
    convPhase = (state == ST_CONV) && !calReq;
    modeNow   = modeCode_e'({m1Reg, sdi});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      calCnt   <= '0;
      longSel  <= 1'b0;
      m1Reg    <= 1'b0;
      calReq   <= 1'b0;
      sleepReq <= 1'b0;
      rangeReg <= 1'b0;
    end else if (!shdnN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      calCnt <= '0;
    end else if (startOk) begin
      state    <= ST_CONV;
      cnt      <= CNT_W'(1);
      calCnt   <= '0;
      calReq   <= 1'b0;
      sleepReq <= 1'b0;
    end else begin
      case (state)
        ST_CONV: begin
          if (cnt == CNT_W'(RANGE_POS)) rangeReg <= sdi;
          if (cnt == CNT_W'(M1_POS))    m1Reg    <= sdi;
          if (cnt == CNT_W'(M0_POS)) begin
            case (modeNow)
              MD_SHORT: longSel <= 1'b0;
              MD_LONG:  longSel <= 1'b1;
              default:  ;
            endcase
            calReq   <= (modeNow == MD_CAL);
            sleepReq <= (modeNow == MD_SLEEP);
          end
          if (calReq && cnt == CNT_W'(LAST_CTRL)) begin
            state  <= ST_CAL;
            cnt    <= '0;
            calCnt <= '0;
          end else if (!calReq && cnt == periodEnd) begin
            state <= sleepReq ? ST_SLEEP : ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CAL: begin
          if (calCnt == CAL_W'(CAL_CYCLES - 1)) state <= ST_IDLE;
          else calCnt <= calCnt + CAL_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    acqActive      = convPhase && (cnt <= acqEnd);
    strobe.capture = convPhase && (cnt == acqEnd);
    strobe.shiftOn = convPhase && (cnt >= outFirst);
    strobe.bipolar = rangeReg;
    rangeBip       = rangeReg;
    calBusy        = (state == ST_CAL);
    sleepFlag      = (state == ST_SLEEP) || !shdnN;
  end

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcConvSeqPkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [RES_W-1:0] level,
  output logic             sdo
);

  localparam logic [RES_W-1:0] SIGN_FLIP = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] shReg;

  // falling-edge domain: capture, then shift out MSB first
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      sdo   <= 1'b0;
    end else begin
      if (strobe.capture)
        shReg <= strobe.bipolar ? (level ^ SIGN_FLIP) : level;
      else if (strobe.shiftOn)
        shReg <= shReg << 1;
      sdo <= strobe.shiftOn ? shReg[RES_W-1] : 1'b0;
    end
  end

endmodule

// File: rtl/adcConvSeq.sv
module adcConvSeq
  import adcConvSeqPkg::*;
#(
  parameter int RES_W         = 16,
  parameter int CTRL_W        = 8,
  parameter int SHORT_ACQ_END = 6,
  parameter int LONG_EXTRA    = 8,
  parameter int CAL_CYCLES    = 80000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shdnN,
  input  logic             sdi,
  input  logic [RES_W-1:0] anaLevel,
  output logic             sdo,
  output logic             acqActive,
  output logic             rangeBip,
  output logic             calBusy,
  output logic             sleepFlag
);

  dpStrobe_t strobe;

  adcSeqCtrl #(
    .RES_W(RES_W), .CTRL_W(CTRL_W), .SHORT_ACQ_END(SHORT_ACQ_END),
    .LONG_EXTRA(LONG_EXTRA), .CAL_CYCLES(CAL_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .sdi(sdi),
    .strobe(strobe), .acqActive(acqActive), .rangeBip(rangeBip),
    .calBusy(calBusy), .sleepFlag(sleepFlag)
  );

  adcSeqData #(.RES_W(RES_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .level(anaLevel), .sdo(sdo)
  );

endmodule

// File: rtl/adcConvSeqChk.sv
module adcConvSeqChk
  import adcConvSeqPkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int LONG_PERIOD = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             shdnN,
  input logic             sdi,
  input seqState_e        state,
  input logic [CNT_W-1:0] cnt,
  input dpStrobe_t        strobe,
  input logic             acqActive,
  input logic             rangeBip,
  input logic             calBusy
);

  p_start_acq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_CONV && shdnN && sdi) |=> (state == ST_CONV && acqActive));

  p_range_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnt != CNT_W'(1)) |=> $stable(rangeBip));

  p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acqActive, strobe.shiftOn, calBusy}));

  p_period_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> (cnt <= CNT_W'(LONG_PERIOD)));

  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !(shdnN && sdi)) |=> (state != ST_CONV));

  p_cal_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calBusy) |-> ($past(state) == ST_CONV && !acqActive));

  p_cal_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && shdnN && sdi) |=> (acqActive && !calBusy));

  p_shdn_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |=> (state == ST_IDLE && !acqActive && !calBusy));

endmodule

bind adcSeqCtrl adcConvSeqChk #(.CNT_W(CNT_W), .LONG_PERIOD(LONG_PERIOD)) chk_i (
  .clk(clk), .rstN(rstN), .shdnN(shdnN), .sdi(sdi), .state(state),
  .cnt(cnt), .strobe(strobe), .acqActive(acqActive), .rangeBip(rangeBip),
  .calBusy(calBusy)
);

// File: tb/adcConvSeq_tb_top.sv
module adcConvSeq_tb_top;

  localparam int CAL_N = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shdnN = 1'b1;
  logic        sdi = 1'b0;
  logic [15:0] anaLevel = 16'h0000;
  logic        sdo, acqActive, rangeBip, calBusy, sleepFlag;

  int    vecCount = 0;
  int    missCount = 0;
  int    cycCount = 0;
  bit    doneRun = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  adcConvSeq #(.CAL_CYCLES(CAL_N)) dut_i (
    .clk(clk), .rstN(rstN), .shdnN(shdnN), .sdi(sdi), .anaLevel(anaLevel),
    .sdo(sdo), .acqActive(acqActive), .rangeBip(rangeBip),
    .calBusy(calBusy), .sleepFlag(sleepFlag)
  );

  // behavioural reference: 0 idle, 1 converting, 2 calibrating, 3 asleep
  int          mState = 0;
  int          mCnt = 0;
  int          mCalCnt = 0;
  int          mLong = 0;
  int          mM1 = 0;
  int          mCalR = 0;
  int          mSlpR = 0;
  int          mRange = 0;
  logic [15:0] mCode = 16'h0000;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mCalCnt = 0; mLong = 0; mM1 = 0;
      mCalR = 0; mSlpR = 0; mRange = 0; mCode = 16'h0000;
    end else if (!shdnN) begin
      mState = 0; mCnt = 0;
    end else if (sdi && mState != 1) begin
      mState = 1; mCnt = 1; mCalR = 0; mSlpR = 0;
    end else if (mState == 2) begin
      if (mCalCnt == CAL_N - 1) mState = 0;
      else mCalCnt++;
    end else if (mState == 1) begin
      if (mCnt == 1) mRange = int'(sdi);
      if (mCnt == 2) mM1 = int'(sdi);
      if (mCnt == 3) begin
        int code;
        code = 2 * mM1 + int'(sdi);
        if (code == 0) mLong = 0;
        if (code == 3) mLong = 1;
        mCalR = (code == 1) ? 1 : 0;
        mSlpR = (code == 2) ? 1 : 0;
      end
      if (mCalR == 1 && mCnt == 7) begin
        mState = 2; mCnt = 0; mCalCnt = 0;
      end else if (mCalR == 0 && mCnt == 24 + 8 * mLong) begin
        mState = (mSlpR == 1) ? 3 : 0; mCnt = 0;
      end else begin
        mCnt++;
        if (mCalR == 0 && mCnt == 6 + 8 * mLong)
          mCode = (mRange == 1) ? (anaLevel ^ 16'h8000) : anaLevel;
      end
    end
  end

  task automatic chk1(input string sigTag, input string sigName, input logic got, input logic exp);
    vecCount++;
    if (got !== exp) begin
      missCount++;
      $display("FAIL %s/%s %s: got %b expected %b at %0t", curReq, sigTag, sigName, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    int  per;
    bit  conv;
    logic expAcq, expSdo;
    per    = 24 + 8 * mLong;
    conv   = (mState == 1) && (mCalR == 0);
    expAcq = rstN && conv && (mCnt <= 6 + 8 * mLong);
    expSdo = rstN && conv && (mCnt >= per - 15) && mCode[per - mCnt];
    chk1("R4", "acqActive", acqActive, expAcq);
    chk1("R9", "sdo", sdo, expSdo);
    chk1("R3", "rangeBip", rangeBip, (mRange == 1));
    chk1("R7", "calBusy", calBusy, (mState == 2));
    chk1("R6", "sleepFlag", sleepFlag, (mState == 3) || !shdnN);
  endtask

  // sample away from both edges: 3 ns after the falling edge
  always @(negedge clk) begin
    #3;
    if (!doneRun) compareAll();
  end

  task automatic finishRun();
    doneRun = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 5000 && !doneRun) begin
      missCount++;
      $display("FAIL watchdog: got %0d cycles expected at most 5000", cycCount);
      finishRun();
    end
  end

  task automatic drv(input logic b);
    @(negedge clk); #1; sdi = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0);
  endtask

  task automatic sendCtrl(input logic rng, input logic [1:0] md, input logic [3:0] pad);
    drv(1'b1); drv(rng); drv(md[1]); drv(md[0]);
    for (int i = 3; i >= 0; i--) drv(pad[i]);
    drv(1'b0);
  endtask

  task automatic setShdn(input logic v);
    @(negedge clk); #1; shdnN = v;
  endtask

  task automatic setRst(input logic v);
    @(negedge clk); #1; rstN = v;
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(3);
    setRst(1'b1);
    idle(2);

    // R4: short unipolar conversion
    curReq = "R4"; anaLevel = 16'h1234;
    sendCtrl(1'b0, 2'b00, 4'h0); idle(24);

    // R3: switch to bipolar, small level gives negative code
    curReq = "R3"; anaLevel = 16'h0001;
    sendCtrl(1'b1, 2'b00, 4'h0); idle(24);

    // R5: long bipolar, top level
    curReq = "R5"; anaLevel = 16'hFFFF;
    sendCtrl(1'b1, 2'b11, 4'h0); idle(32);

    // R6: sleep code reuses long length, then sleeps
    curReq = "R6"; anaLevel = 16'h8000;
    sendCtrl(1'b0, 2'b10, 4'h0); idle(40);

    // R2: wake from sleep, previous range holds until range bit
    curReq = "R2"; anaLevel = 16'h5A5A;
    sendCtrl(1'b1, 2'b00, 4'h0); idle(24);

    // R10: pad bits high and sdi high in the output window
    curReq = "R10"; anaLevel = 16'hC3C3;
    sendCtrl(1'b0, 2'b00, 4'hF);
    for (int i = 0; i < 15; i++) drv(1'b1);
    idle(8);

    // R7: calibration to completion
    curReq = "R7";
    sendCtrl(1'b0, 2'b01, 4'h0); idle(CAL_N + 6);

    // R8: calibration cut short by a start bit
    curReq = "R8"; anaLevel = 16'h0F0F;
    sendCtrl(1'b0, 2'b01, 4'h0); idle(10);
    sendCtrl(1'b0, 2'b00, 4'h0); idle(24);

    // R8: calibration cut short by the shutdown pin, R11 starts ignored
    sendCtrl(1'b0, 2'b01, 4'h0); idle(5);
    curReq = "R11";
    setShdn(1'b0);
    for (int i = 0; i < 4; i++) drv(1'b1);
    drv(1'b0);
    setShdn(1'b1);
    idle(5);

    // R11: shutdown in the middle of a long result
    anaLevel = 16'hA5A5;
    sendCtrl(1'b1, 2'b11, 4'h0); idle(14);
    setShdn(1'b0); idle(3); setShdn(1'b1); idle(5);

    // R8: calibration cut short by reset, R1 length and range cleared
    curReq = "R8";
    sendCtrl(1'b1, 2'b01, 4'h0); idle(5);
    setRst(1'b0); idle(2); setRst(1'b1); idle(5);
    curReq = "R1"; anaLevel = 16'h7777;
    sendCtrl(1'b0, 2'b10, 4'h0); idle(30);

    finishRun();
  end

endmodule